// File: doc/BRIEF.md
# CPU Clock Divider with Main Clock Output

This block produces the CPU clock enable from the oscillator clock and, when enabled, drives a half-rate copy of that clock onto an output pin. A single 8-bit control register, loaded through a simple write strobe, holds four fields. The first is a mode bit that chooses between normal and slow operation. The second is a 2-bit prescaler code that picks the slow-mode divisor. The third is an output-enable bit for the clock pin. The last is two 2-bit external-interrupt sensitivity fields, which are only stored here and passed on to the interrupt logic.

In normal mode the CPU clock enable is one oscillator cycle wide and recurs every 2 cycles. In slow mode it recurs every 4, 8, 16 or 32 cycles. The divider is a free-running counter. A new divisor is taken up only at the end of the current period, so the CPU never sees a shortened period. The clock output comes from a toggle flop. It is held low, and its pin-select line is released, whenever the enable bit is clear or the active-halt input is high.

Top module: `cpu_clk_divider`

## Requirements
- R1: After reset, every register bit reads 0, `cpu_ce`, `clk_out` and `clk_out_sel` are low, and the block runs in normal mode.
- R2: With the slow bit (bit 0) at 0, `cpu_ce` is high for exactly one cycle in every 2. It never stays high for two consecutive cycles in any mode.
- R3: With the slow bit at 1, the prescaler code in bits 2:1 sets the `cpu_ce` period: code 00 gives 4 cycles, 01 gives 8, 10 gives 16 and 11 gives 32.
- R4: While the slow bit is 0, the prescaler code has no effect on `cpu_ce`.
- R5: A divisor change written mid-period takes effect only once the running period completes, at the next `cpu_ce` pulse. The period that was in progress keeps its old length.
- R6: With bit 5 at 1 and `active_halt` low, `clk_out` toggles on every clock edge, giving the oscillator divided by 2, and `clk_out_sel` is high. Both follow the condition one cycle later.
- R7: While `active_halt` is high, `clk_out` and `clk_out_sel` are low from the next cycle on, whatever bit 5 holds.
- R8: With bit 5 at 0, `clk_out` and `clk_out_sel` are low from the next cycle on.
- R9: The sensitivity fields (bits 7:6 to `sens_hi`, bits 4:3 to `sens_lo`) are loaded by a write only while `irq_masked` is high. A write with `irq_masked` low leaves them unchanged but still updates bits 5, 2, 1 and 0.
- R10: `rd_data` shows the register content in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| irq_masked | input | 1 | High while CPU interrupts are masked; gates sensitivity writes |
| active_halt | input | 1 | High during the active-halt power mode |
| rd_data | output | 8 | Register content |
| sens_hi | output | 2 | Sensitivity field from bits 7:6 |
| sens_lo | output | 2 | Sensitivity field from bits 4:3 |
| cpu_ce | output | 1 | One-cycle CPU clock enable pulse |
| clk_out | output | 1 | Divided clock for the output pin |
| clk_out_sel | output | 1 | High when the pin carries the clock, low for general I/O |

## Verification
The assertions assume that `wr_en` is one cycle wide and that every input is stable at the sampling edge. They also assume that `active_halt` and `irq_masked` can change in any cycle, including the cycle of a write. The stimulus drives all inputs on the falling edge. The random phase picks writes of arbitrary data with arbitrary mask state and toggles of the halt input at random moments, so divisor changes land at every point of the count. A cycle model built from the requirements predicts each output on every cycle.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

  localparam int REG_W = 8;

  // Register layout (MSB first): sens_hi[7:6], co_en[5], sens_lo[4:3], cp[2:1], slow[0]
  typedef struct packed {
    logic [1:0] sens_hi;
    logic       co_en;
    logic [1:0] sens_lo;
    logic [1:0] cp;
    logic       slow;
  } ctrl_t;

  // log2 of the CPU clock divisor
  function automatic logic [7:0] div_shift(input logic slow, input logic [1:0] cp);
    if (slow) div_shift = 8'd2 + {6'd0, cp};
    else      div_shift = 8'd1;
  endfunction

endpackage

// File: rtl/ckdiv_ctrl_reg.sv
module ckdiv_ctrl_reg
  import ckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_masked,
  output ctrl_t            ctrl_o
);

  ctrl_t ctrl_q;
  ctrl_t wd;

  assign wd = ctrl_t'(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.slow  <= wd.slow;
      ctrl_q.cp    <= wd.cp;
      ctrl_q.co_en <= wd.co_en;
      if (irq_masked) begin
        ctrl_q.sens_hi <= wd.sens_hi;
        ctrl_q.sens_lo <= wd.sens_lo;
      end
    end
  end

  assign ctrl_o = ctrl_q;

  // R9
  sens_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !irq_masked) |=> ($stable(ctrl_q.sens_hi) && $stable(ctrl_q.sens_lo)));

  // R10
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctrl_q.slow == $past(wd.slow)) && (ctrl_q.cp == $past(wd.cp))
              && (ctrl_q.co_en == $past(wd.co_en)));

endmodule

// File: rtl/ckdiv_ce_gen.sv
module ckdiv_ce_gen
  import ckdiv_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SH_W  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow,
  input  logic [1:0] cp,
  output logic       cpu_ce
);

  localparam logic [SH_W-1:0] RST_SH = SH_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [SH_W-1:0]  sh_q;
  logic [SH_W-1:0]  sh_next;
  logic             tc;
  logic             ce_q;

  assign lim     = CNT_W'((32'd1 << sh_q) - 32'd1);
  assign tc      = (cnt_q == lim);
  assign sh_next = SH_W'(div_shift(slow, cp));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sh_q  <= RST_SH;
      ce_q  <= 1'b0;
    end else begin
      ce_q <= tc;
      if (tc) begin
        cnt_q <= '0;
        sh_q  <= sh_next;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cpu_ce = ce_q;

  // R2
  ce_single_chk: assert property (@(posedge clk) disable iff (rst)
    ce_q |=> !ce_q);

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tc |=> $stable(sh_q));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim);

endmodule

// File: rtl/ckdiv_clkout.sv
module ckdiv_clkout (
  input  logic clk,
  input  logic rst,
  input  logic co_en,
  input  logic halt,
  output logic clk_out,
  output logic pin_sel
);

  logic en;
  logic co_q;
  logic sel_q;

  assign en = co_en & ~halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      co_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= en;
      co_q  <= en ? ~co_q : 1'b0;
    end
  end

  assign clk_out = co_q;
  assign pin_sel = sel_q;

  // R6
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (co_q != $past(co_q)) && sel_q);

  // R7
  halt_off_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> (!co_q && !sel_q));

  // R8
  disabled_off_chk: assert property (@(posedge clk) disable iff (rst)
    !co_en |=> (!co_q && !sel_q));

endmodule

// File: rtl/cpu_clk_divider.sv
module cpu_clk_divider
  import ckdiv_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_masked,
  input  logic             active_halt,
  output logic [REG_W-1:0] rd_data,
  output logic [1:0]       sens_hi,
  output logic [1:0]       sens_lo,
  output logic             cpu_ce,
  output logic             clk_out,
  output logic             clk_out_sel
);

  ctrl_t ctrl;

  ckdiv_ctrl_reg u_reg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .irq_masked (irq_masked),
    .ctrl_o     (ctrl)
  );

  ckdiv_ce_gen #(
    .CNT_W (CNT_W),
    .SH_W  (SH_W)
  ) u_ce (
    .clk    (clk),
    .rst    (rst),
    .slow   (ctrl.slow),
    .cp     (ctrl.cp),
    .cpu_ce (cpu_ce)
  );

  ckdiv_clkout u_co (
    .clk     (clk),
    .rst     (rst),
    .co_en   (ctrl.co_en),
    .halt    (active_halt),
    .clk_out (clk_out),
    .pin_sel (clk_out_sel)
  );

  assign rd_data = REG_W'(ctrl);
  assign sens_hi = ctrl.sens_hi;
  assign sens_lo = ctrl.sens_lo;

endmodule

// File: tb/tb_cpu_clk_divider.sv
module tb_cpu_clk_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_masked = 1'b0;
  logic       active_halt = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] sens_hi, sens_lo;
  logic       cpu_ce, clk_out, clk_out_sel;

  always #5 clk = ~clk;

  cpu_clk_divider dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .irq_masked(irq_masked), .active_halt(active_halt),
    .rd_data(rd_data), .sens_hi(sens_hi), .sens_lo(sens_lo),
    .cpu_ce(cpu_ce), .clk_out(clk_out), .clk_out_sel(clk_out_sel)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    started = 0;
  bit    done = 0;
  string ce_tag = "R2";
  string co_tag = "R8";
  string rg_tag = "R10";

  // reference model built from the requirements
  logic [7:0] m_reg;
  int         m_cnt, m_sh;
  logic       m_ce, m_co, m_sel;

  function automatic int exp_shift(input logic [7:0] r);
    return r[0] ? 2 + int'(r[2:1]) : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reg <= 8'h00; m_cnt <= 0; m_sh <= 1;
      m_ce <= 1'b0; m_co <= 1'b0; m_sel <= 1'b0;
    end else begin
      automatic bit tcm = (m_cnt == (1 << m_sh) - 1);
      automatic bit en  = m_reg[5] && !active_halt;
      m_ce  <= tcm;
      m_cnt <= tcm ? 0 : m_cnt + 1;
      if (tcm) m_sh <= exp_shift(m_reg);
      m_co  <= en ? !m_co : 1'b0;
      m_sel <= en;
      if (wr_en)
        m_reg <= {irq_masked ? wr_data[7:6] : m_reg[7:6], wr_data[5],
                  irq_masked ? wr_data[4:3] : m_reg[4:3], wr_data[2:0]};
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      check(ce_tag, "cpu_ce", int'(cpu_ce), int'(m_ce));
      check(co_tag, "clk_out", int'(clk_out), int'(m_co));
      check(co_tag, "clk_out_sel", int'(clk_out_sel), int'(m_sel));
      check(rg_tag, "rd_data", int'(rd_data), int'(m_reg));
      check("R9", "sens_hi", int'(sens_hi), int'(m_reg[7:6]));
      check("R9", "sens_lo", int'(sens_lo), int'(m_reg[4:3]));
    end
  end

  task automatic wr(input logic [7:0] d, input logic m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; irq_masked = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "rd_data", int'(rd_data), 0);
    check("R1", "clk_out", int'(clk_out), 0);
    check("R1", "clk_out_sel", int'(clk_out_sel), 0);
    check("R1", "cpu_ce", int'(cpu_ce), 0);
    started = 1;

    ce_tag = "R2"; run(40);
    ce_tag = "R4"; wr(8'h06, 1'b1); run(40); wr(8'h04, 1'b0); run(20);
    ce_tag = "R3";
    for (int c = 0; c < 4; c++) begin
      wr({5'b0, 2'(c), 1'b1}, 1'b1);
      run(80);
    end
    ce_tag = "R5";
    wr(8'h07, 1'b1); run(50); wr(8'h01, 1'b1); run(60);
    wr(8'h05, 1'b1); run(3); wr(8'h00, 1'b1); run(30);
    co_tag = "R6"; wr(8'h20, 1'b1); run(20);
    co_tag = "R7"; active_halt = 1'b1; run(10);
    co_tag = "R6"; active_halt = 1'b0; run(10);
    co_tag = "R8"; wr(8'h00, 1'b1); run(10);
    rg_tag = "R9";
    wr(8'hD8, 1'b0); run(3);
    wr(8'hD8, 1'b1); run(3);
    wr(8'h03, 1'b0); run(3);
    rg_tag = "R10";

    ce_tag = "R3"; co_tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      automatic int act = int'($urandom % 8);
      if (act == 0) wr(8'($urandom), 1'($urandom));
      else if (act == 1) begin @(negedge clk); active_halt = ~active_halt; end
      else run(1 + int'($urandom % 20));
    end
    run(40);
    done = 1;
    summary();
    $finish;
  end

endmodule